// File: doc/BRIEF.md
# Complex Scrambling Chip Mapper

This block turns two 16-chip binary pseudo-noise words, called c1 and c2, into 16 complex scrambling chips on each valid step. Each chip has a real and an imaginary component. Each component takes the value +1 or -1 and leaves the block as one bit. The real component is the c1 chip taken as it is. The imaginary component is the product of three antipodal factors: the c1 chip, a decimated c2 chip, and a sign that alternates with the parity of the chip index.

Chip i of a word sits at bit position i, and bit 0 is the earliest chip. Every word begins at an even chip index, so the parity of a chip is the parity of its bit position. Only the c2 chips at even positions are used. Each of them serves its own chip and the odd chip that follows it. The results are registered, and a valid flag follows them one cycle after the input word.

Top module: `cscr_chip_mapper`

## Requirements
- R1: While reset is high, the next clock edge sets out_valid to 0 and sets re_bits and im_bits to all zeros.
- R2: out_valid is in_valid delayed by exactly one clock cycle, outside reset.
- R3: One cycle after a valid word, re_bits[i] equals c1_word[i] for every i. A bit value of 0 stands for +1 and a bit value of 1 stands for -1.
- R4: One cycle after a valid word, im_bits[i] equals c1_word[i] XOR c2_word[i with bit 0 cleared] XOR (i mod 2). This is the antipodal product of c1, decimated c2 and the parity sign, where the sign is -1 for odd i.
- R5: The c2 bits at odd positions have no effect on either output.
- R6: A cycle with in_valid low leaves re_bits and im_bits unchanged.
- R7: With all-zero inputs, the imaginary word is 0xAAAA for 16 chips. Only the odd chips carry -1, from the parity sign alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies c1_word and c2_word |
| c1_word | input | N (16) | c1 chips, chip i at bit i |
| c2_word | input | N (16) | c2 chips, chip i at bit i |
| out_valid | output | 1 | Qualifies re_bits and im_bits |
| re_bits | output | N (16) | Real components, 0 = +1, 1 = -1 |
| im_bits | output | N (16) | Imaginary components, 0 = +1, 1 = -1 |

## Verification
The assertions check on every cycle that the reset state is clean, that the valid flag trails its input by one cycle, and that idle cycles hold the outputs. They also check that both output words follow from the previous input word. The imaginary word is checked by a pairwise form that is independent of the datapath. Only the bench scenarios can show that the odd c2 bits are ignored, since that needs two words compared side by side. The bench also covers the fixed all-zero and all-one patterns and recovery from a reset in the middle of a run.

// File: rtl/cscr_pkg.sv
package cscr_pkg;

    localparam int DEF_CHIPS = 16;

    typedef enum logic {
        SYM_POS = 1'b0,
        SYM_NEG = 1'b1
    } antipodal_e;

    typedef struct packed {
        logic re;
        logic im;
    } cplx_chip_t;

    // Product of two antipodal symbols in bit encoding
    function automatic antipodal_e sym_mul(antipodal_e a, antipodal_e b);
        return antipodal_e'(a ^ b);
    endfunction

    function automatic cplx_chip_t map_chip(logic c1_bit, logic c2_bit, logic odd);
        cplx_chip_t  c;
        antipodal_e  sign;
        sign = odd ? SYM_NEG : SYM_POS;
        c.re = c1_bit;
        c.im = sym_mul(sym_mul(antipodal_e'(c1_bit), antipodal_e'(c2_bit)), sign);
        return c;
    endfunction

endpackage

// File: rtl/cscr_pair_slice.sv
module cscr_pair_slice
    import cscr_pkg::*;
(
    input  logic       [1:0] c1_pair,
    input  logic       [1:0] c2_pair,
    output cplx_chip_t [1:0] chips
);
    // Decimation: the even c2 chip serves both lanes of the pair
    logic unused_c2_odd;
    assign unused_c2_odd = c2_pair[1];

    always_comb begin
        chips[0] = map_chip(c1_pair[0], c2_pair[0], 1'b0);
        chips[1] = map_chip(c1_pair[1], c2_pair[0], 1'b1);
    end
endmodule

// File: rtl/cscr_out_stage.sv
module cscr_out_stage #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [N-1:0] re_d,
    input  logic [N-1:0] im_d,
    output logic         valid_q,
    output logic [N-1:0] re_q,
    output logic [N-1:0] im_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            re_q    <= '0;
            im_q    <= '0;
        end else begin
            valid_q <= load;
            if (load) begin
                re_q <= re_d;
                im_q <= im_d;
            end
        end
    end
endmodule

// File: rtl/cscr_chip_mapper.sv
module cscr_chip_mapper
    import cscr_pkg::*;
#(
    parameter int N = DEF_CHIPS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [N-1:0] c1_word,
    input  logic [N-1:0] c2_word,
    output logic         out_valid,
    output logic [N-1:0] re_bits,
    output logic [N-1:0] im_bits
);
    localparam int PAIRS = N / 2;

    cplx_chip_t [N-1:0] chip_vec;
    logic       [N-1:0] re_next;
    logic       [N-1:0] im_next;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        cscr_pair_slice u_slice (
            .c1_pair (c1_word[2*p +: 2]),
            .c2_pair (c2_word[2*p +: 2]),
            .chips   (chip_vec[2*p +: 2])
        );
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            re_next[i] = chip_vec[i].re;
            im_next[i] = chip_vec[i].im;
        end
    end

    cscr_out_stage #(.N(N)) u_out (
        .clk     (clk),
        .rst     (rst),
        .load    (in_valid),
        .re_d    (re_next),
        .im_d    (im_next),
        .valid_q (out_valid),
        .re_q    (re_bits),
        .im_q    (im_bits)
    );
endmodule

// File: rtl/cscr_chip_mapper_chk.sv
module cscr_chip_mapper_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [N-1:0] c1_word,
    input logic [N-1:0] c2_word,
    input logic         out_valid,
    input logic [N-1:0] re_bits,
    input logic [N-1:0] im_bits
);
    // Pairwise view: c2 even chip spread over its pair, sign mask on odd lanes
    logic [N-1:0] c2_spread;
    logic [N-1:0] odd_mask;
    always_comb begin
        for (int k = 0; k < N; k++) begin
            c2_spread[k] = c2_word[k - (k % 2)];
            odd_mask[k]  = (k % 2) == 1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!out_valid && re_bits == '0 && im_bits == '0)); // R1

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid) || $past(rst)); // R2

    AST_REAL_PATH: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> re_bits == $past(c1_word)); // R3

    AST_IMAG_PATH: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (im_bits ^ re_bits) == $past(c2_spread ^ odd_mask)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(re_bits) && $stable(im_bits))); // R6
endmodule

bind cscr_chip_mapper cscr_chip_mapper_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .c1_word   (c1_word),
    .c2_word   (c2_word),
    .out_valid (out_valid),
    .re_bits   (re_bits),
    .im_bits   (im_bits)
);

// File: tb/cscr_chip_mapper_test.sv
module cscr_chip_mapper_test;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [N-1:0] c1_word = '0;
    logic [N-1:0] c2_word = '0;
    logic         out_valid;
    logic [N-1:0] re_bits;
    logic [N-1:0] im_bits;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [N-1:0] exp_re = '0;
    logic [N-1:0] exp_im = '0;

    always #2 clk = ~clk;

    cscr_chip_mapper #(.N(N)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .c1_word(c1_word), .c2_word(c2_word),
        .out_valid(out_valid), .re_bits(re_bits), .im_bits(im_bits)
    );

    function automatic logic [N-1:0] model_im(logic [N-1:0] a, logic [N-1:0] b);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            int e = (i / 2) * 2;
            r[i] = a[i] ^ b[e] ^ logic'(i % 2);
        end
        return r;
    endfunction

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at negedge, output visible after next posedge, sample at following negedge
    task automatic step(logic v, logic [N-1:0] a, logic [N-1:0] b);
        in_valid = v; c1_word = a; c2_word = b;
        @(negedge clk);
        if (v) begin
            exp_re = a;
            exp_im = model_im(a, b);
        end
        check("R2 valid", {15'd0, out_valid}, {15'd0, v});
        check("R3 real", re_bits, exp_re);
        check("R4 imag", im_bits, exp_im);
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 1'b1; c1_word = 16'hFFFF; c2_word = 16'hFFFF;
        @(negedge clk);
        @(negedge clk);
        check("R1 valid", {15'd0, out_valid}, 16'd0);
        check("R1 real", re_bits, 16'd0);
        check("R1 imag", im_bits, 16'd0);
        rst = 1'b0; in_valid = 1'b0;
        exp_re = '0; exp_im = '0;
    endtask

    initial begin
        logic [N-1:0] im_a;
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R7: all-zero words give the parity pattern alone
        step(1'b1, 16'h0000, 16'h0000);
        check("R7 zero", im_bits, 16'hAAAA);
        step(1'b1, 16'hFFFF, 16'hFFFF);
        step(1'b1, 16'h0000, 16'h5555);
        step(1'b1, 16'h1234, 16'h8001);

        // R6: idle cycles keep outputs, inputs changing underneath
        step(1'b0, 16'hDEAD, 16'hBEEF);
        step(1'b0, 16'h0F0F, 16'hF0F0);
        check("R6 hold real", re_bits, 16'h1234);

        // R5: odd c2 bits toggled, outputs must match
        for (int t = 0; t < 20; t++) begin
            logic [N-1:0] a = N'($urandom);
            logic [N-1:0] b = N'($urandom);
            step(1'b1, a, b);
            im_a = im_bits;
            step(1'b1, a, b ^ 16'hAAAA);
            check("R5 odd c2 ignored", im_bits, im_a);
        end

        // Random mix of valid and idle
        for (int t = 0; t < 300; t++) begin
            step(logic'($urandom_range(0, 3) != 0), N'($urandom), N'($urandom));
        end

        // R1 mid-run reset
        do_reset();
        step(1'b1, 16'hC3A5, 16'h7E81);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule